// File: doc/BRIEF.md
# Transparent Serial Byte Transmitter

This block sends raw bytes onto a single serial data line with no framing of any kind: no flag octets, no zero insertion and no check sequence. Bytes come from an external transmit FIFO through a valid/pop handshake. One bit leaves per pulse of a bit-rate enable that is derived from the data-link bit clock. Each byte goes out least significant bit first. Octet boundaries are counted from the first bit pulse after the transmitter is enabled.

When a boundary arrives and the FIFO is empty, the line is filled for one octet. The fill is either all ones or a programmable idle byte, chosen by a select input that is sampled at that boundary. A FIFO byte is taken only at an octet boundary, so a byte that arrives part-way through a fill octet waits for the next boundary. A one-cycle done pulse marks the first empty boundary that follows a data octet, which tells the user that transmission has ended. A soft transmitter reset, or dropping the enable, forces the line high and returns the octet counter to zero.

A controller has three states. `S_OFF` means disabled or held in reset. `S_DATA` means the current octet holds a FIFO byte. `S_FILL` means the current octet holds fill. The transitions are as follows. Any state goes to `S_OFF` on clear. At a boundary bit pulse, `S_OFF`, `S_DATA` and `S_FILL` each go to `S_DATA` if the FIFO has a byte, and to `S_FILL` otherwise. With no boundary bit pulse, the state holds.

Top module: `tpx_serial_tx`

## Requirements
- R1: While `tx_enable` is 0 (and after `rst_n`), `ser_out` is 1, `fifo_pop` is 0 and `tx_done` is 0.
- R2: A FIFO byte appears on `ser_out` bit 0 first and bit 7 last, one bit per bit pulse. Each bit is visible from the cycle after its `bit_en` pulse.
- R3: With no `bit_en` pulse, `ser_out` keeps its value.
- R4: The first `bit_en` pulse after enable or after a soft reset starts a new octet.
- R5: `fifo_pop` is high for exactly one cycle per byte taken, only on a boundary `bit_en` pulse with `fifo_valid` = 1. A byte that arrives mid-octet is not taken until the next boundary.
- R6: At a boundary with the FIFO empty and `idle_sel` = 0, the octet is eight 1 bits.
- R7: At a boundary with the FIFO empty and `idle_sel` = 1, the octet is `idle_char`, sent LSB first, sampled at that boundary.
- R8: `tx_reset` = 1 drives `ser_out` to 1 in the next cycle, drops any partly sent byte, and returns the octet count to zero.
- R9: `tx_done` pulses high for one cycle, in the cycle after a boundary pulse that finds the FIFO empty when the previous octet was a FIFO byte.
- R10: Bytes that are available at successive boundaries go out back to back, with no fill between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_enable | input | 1 | Transmitter enable |
| tx_reset | input | 1 | Synchronous soft transmitter reset |
| bit_en | input | 1 | One-cycle pulse per serial bit |
| idle_sel | input | 1 | 1 = send idle_char when starved, 0 = all ones |
| idle_char | input | 8 | Programmable idle byte |
| fifo_valid | input | 1 | FIFO holds a byte |
| fifo_data | input | 8 | Byte at the FIFO head |
| fifo_pop | output | 1 | Take the head byte this cycle |
| ser_out | output | 1 | Serial data line |
| tx_done | output | 1 | FIFO ran dry after a data octet |

## Verification
The hardest case to reach is a FIFO byte that arrives in the middle of a fill octet. It must wait for the boundary and must not shorten the fill. The stimulus reaches this case in two ways. A directed step pushes a byte after exactly three bits of an idle octet. A long random phase also pushes bytes at random cycles while the bit pulses are sparse. Each octet then spans many cycles, so arrivals land at every bit position, and a cycle-accurate bench model catches any early pop. The soft reset is also fired at random bit positions to test realignment.

// File: rtl/tpx_pkg.sv
package tpx_pkg;
    typedef enum logic [1:0] {
        S_OFF  = 2'd0,
        S_DATA = 2'd1,
        S_FILL = 2'd2
    } tpx_state_e;
endpackage

// File: rtl/tpx_src_mux.sv
module tpx_src_mux #(
    parameter int W = 8
) (
    input  logic         take_fifo,
    input  logic         idle_sel,
    input  logic [W-1:0] idle_char,
    input  logic [W-1:0] fifo_data,
    output logic [W-1:0] load_val
);
    localparam logic [W-1:0] ALL_ONES = '1;

    always_comb begin
        if (take_fifo)
            load_val = fifo_data;
        else if (idle_sel)
            load_val = idle_char;
        else
            load_val = ALL_ONES;
    end
endmodule

// File: rtl/tpx_shifter.sv
module tpx_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         step,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         at_boundary,
    output logic         ser_out
);
    localparam int CW = (W > 1) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LAST = CW'(W - 1);
    localparam logic [CW-1:0] ONE  = CW'(1);

    logic [CW-1:0] bit_cnt;
    logic [W-1:0]  shreg;

    assign at_boundary = (bit_cnt == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            shreg   <= '1;
            ser_out <= 1'b1;
        end else if (clear) begin
            bit_cnt <= '0;
            shreg   <= '1;
            ser_out <= 1'b1;
        end else if (step) begin
            if (load) begin
                ser_out <= load_val[0];
                shreg   <= {1'b1, load_val[W-1:1]};
                bit_cnt <= ONE;
            end else begin
                ser_out <= shreg[0];
                shreg   <= {1'b1, shreg[W-1:1]};
                bit_cnt <= (bit_cnt == LAST) ? '0 : bit_cnt + ONE;
            end
        end
    end
endmodule

// File: rtl/tpx_fsm.sv
module tpx_fsm
    import tpx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic step,
    input  logic at_boundary,
    input  logic fifo_valid,
    output logic fifo_pop,
    output logic load,
    output logic take_fifo,
    output logic tx_done
);
    tpx_state_e state_q, state_d;
    logic       done_set;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_OFF;
            tx_done <= 1'b0;
        end else begin
            state_q <= state_d;
            tx_done <= done_set;
        end
    end

    always_comb begin
        state_d   = state_q;
        fifo_pop  = 1'b0;
        load      = 1'b0;
        take_fifo = 1'b0;
        done_set  = 1'b0;
        if (clear) begin
            state_d = S_OFF;
        end else if (step && at_boundary) begin
            load      = 1'b1;
            take_fifo = fifo_valid;
            fifo_pop  = fifo_valid;
            unique case (state_q)
                S_OFF:   state_d = fifo_valid ? S_DATA : S_FILL;
                S_DATA: begin
                    state_d  = fifo_valid ? S_DATA : S_FILL;
                    done_set = !fifo_valid;
                end
                S_FILL:  state_d = fifo_valid ? S_DATA : S_FILL;
                default: state_d = S_OFF;
            endcase
        end
    end
endmodule

// File: rtl/tpx_serial_tx.sv
module tpx_serial_tx #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tx_enable,
    input  logic         tx_reset,
    input  logic         bit_en,
    input  logic         idle_sel,
    input  logic [W-1:0] idle_char,
    input  logic         fifo_valid,
    input  logic [W-1:0] fifo_data,
    output logic         fifo_pop,
    output logic         ser_out,
    output logic         tx_done
);
    logic         clear;
    logic         at_boundary;
    logic         load;
    logic         take_fifo;
    logic [W-1:0] load_val;

    assign clear = !tx_enable || tx_reset;

    tpx_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear       (clear),
        .step        (bit_en),
        .at_boundary (at_boundary),
        .fifo_valid  (fifo_valid),
        .fifo_pop    (fifo_pop),
        .load        (load),
        .take_fifo   (take_fifo),
        .tx_done     (tx_done)
    );

    tpx_src_mux #(.W(W)) u_mux (
        .take_fifo (take_fifo),
        .idle_sel  (idle_sel),
        .idle_char (idle_char),
        .fifo_data (fifo_data),
        .load_val  (load_val)
    );

    tpx_shifter #(.W(W)) u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear       (clear),
        .step        (bit_en),
        .load        (load),
        .load_val    (load_val),
        .at_boundary (at_boundary),
        .ser_out     (ser_out)
    );
endmodule

// File: rtl/tpx_serial_tx_chk.sv
module tpx_serial_tx_chk #(
    parameter int W = 8
) (
    input logic clk,
    input logic rst_n,
    input logic tx_enable,
    input logic tx_reset,
    input logic bit_en,
    input logic fifo_valid,
    input logic fifo_pop,
    input logic ser_out,
    input logic tx_done
);
    localparam int CW = (W > 1) ? $clog2(W) : 1;
    logic [CW-1:0] obs_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            obs_cnt <= '0;
        else if (!tx_enable || tx_reset)
            obs_cnt <= '0;
        else if (bit_en)
            obs_cnt <= (obs_cnt == CW'(W - 1)) ? '0 : obs_cnt + CW'(1);
    end

    a_r1_off_high: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_enable |=> (ser_out && !tx_done));

    a_r1_no_pop_off: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_enable |-> !fifo_pop);

    a_r3_hold_line: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_enable && !tx_reset && !bit_en) |=> $stable(ser_out));

    a_r5_pop_valid: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |-> (fifo_valid && bit_en));

    a_r5_pop_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |-> (obs_cnt == '0));

    a_r8_reset_high: assert property (@(posedge clk) disable iff (!rst_n)
        tx_reset |=> ser_out);

    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |=> !tx_done);
endmodule

bind tpx_serial_tx tpx_serial_tx_chk #(.W(W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_enable  (tx_enable),
    .tx_reset   (tx_reset),
    .bit_en     (bit_en),
    .fifo_valid (fifo_valid),
    .fifo_pop   (fifo_pop),
    .ser_out    (ser_out),
    .tx_done    (tx_done)
);

// File: tb/tpx_serial_tx_tb_top.sv
module tpx_serial_tx_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_enable = 1'b0, tx_reset = 1'b0, bit_en = 1'b0;
    logic       idle_sel = 1'b0;
    logic [7:0] idle_char = 8'h00;
    logic       fifo_valid = 1'b0;
    logic [7:0] fifo_data = 8'h00;
    logic       fifo_pop, ser_out, tx_done;

    int checks = 0, failures = 0;
    bit finished = 0;
    logic [7:0] q[$];
    bit avail = 1;

    int   m_cnt = 0;
    logic [7:0] m_sh = 8'hFF;
    logic m_out = 1'b1, m_done = 1'b0, m_data = 1'b0;

    always #4 clk = ~clk;

    tpx_serial_tx dut_i (.*);

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(input bit be, input bit en, input bit rs);
        bit clear, epop;
        logic [7:0] b;
        @(negedge clk);
        bit_en = be; tx_enable = en; tx_reset = rs;
        fifo_valid = (q.size() != 0) && avail;
        fifo_data  = (q.size() != 0) ? q[0] : 8'($urandom);
        #1;
        clear = !en || rs;
        epop  = !clear && be && (m_cnt == 0) && fifo_valid;
        chk(fifo_pop == epop, "R5 pop", fifo_pop, epop);
        if (clear) begin
            m_cnt = 0; m_out = 1; m_done = 0; m_data = 0; m_sh = 8'hFF;
        end else if (be) begin
            if (m_cnt == 0) begin
                if (fifo_valid) begin
                    b = fifo_data; m_done = 0; m_data = 1;
                end else begin
                    b = idle_sel ? idle_char : 8'hFF; m_done = m_data; m_data = 0;
                end
                m_out = b[0]; m_sh = {1'b1, b[7:1]}; m_cnt = 1;
            end else begin
                m_out = m_sh[0]; m_sh = {1'b1, m_sh[7:1]};
                m_cnt = (m_cnt + 1) % 8; m_done = 0;
            end
        end else begin
            m_done = 0;
        end
        if (epop) void'(q.pop_front());
        @(posedge clk); #1;
        chk(ser_out == m_out, "R2/R3 ser_out", ser_out, m_out);
        chk(tx_done == m_done, "R9 tx_done", tx_done, m_done);
    endtask

    task automatic octet(output logic [7:0] b);
        for (int i = 0; i < 8; i++) begin
            step(1, 1, 0);
            b[i] = ser_out;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            chk(0, "watchdog", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] got;
        void'($urandom(32'h5EED_0042));
        repeat (3) @(posedge clk);
        #1;
        chk(ser_out == 1'b1 && fifo_pop == 1'b0 && tx_done == 1'b0, "R1 reset", ser_out, 1);
        @(negedge clk); rst_n = 1'b1;
        q.push_back(8'hA5);
        step(1, 0, 0);
        chk(ser_out == 1'b1, "R1 disabled", ser_out, 1);
        step(0, 1, 0); step(0, 1, 0);
        octet(got);
        chk(got == 8'hA5, "R2 R4 lsb first", got, 8'hA5);
        octet(got);
        chk(got == 8'hFF, "R6 ones fill", got, 8'hFF);
        for (int i = 0; i < 5; i++) step(0, 1, 0);
        chk(ser_out == 1'b1, "R3 hold", ser_out, 1);
        idle_sel = 1'b1; idle_char = 8'h3C;
        step(0, 0, 0); step(0, 1, 0);
        octet(got);
        chk(got == 8'h3C, "R7 idle char", got, 8'h3C);
        for (int i = 0; i < 3; i++) step(1, 1, 0);
        q.push_back(8'h96);
        for (int i = 0; i < 5; i++) step(1, 1, 0);
        chk(q.size() == 1, "R5 wait boundary", q.size(), 1);
        octet(got);
        chk(got == 8'h96, "R5 late byte", got, 8'h96);
        q.push_back(8'h81); q.push_back(8'h5A);
        octet(got);
        chk(got == 8'h81, "R10 first", got, 8'h81);
        octet(got);
        chk(got == 8'h5A, "R10 back to back", got, 8'h5A);
        step(1, 1, 0);
        chk(tx_done == 1'b1, "R9 done", tx_done, 1);
        step(1, 1, 0);
        chk(tx_done == 1'b0, "R9 done one cycle", tx_done, 0);
        q.push_back(8'hC3);
        for (int i = 0; i < 3; i++) step(1, 1, 0);
        step(0, 1, 1);
        chk(ser_out == 1'b1, "R8 reset high", ser_out, 1);
        octet(got);
        chk(got == 8'hC3, "R8 R4 realign", got, 8'hC3);
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(0, 19) == 0) q.push_back(8'($urandom));
            avail = ($urandom_range(0, 9) != 0);
            if ($urandom_range(0, 63) == 0) begin
                idle_sel = 1'($urandom); idle_char = 8'($urandom);
            end
            step($urandom_range(0, 3) == 0, $urandom_range(0, 199) != 0,
                 $urandom_range(0, 299) == 0);
        end
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule